// File: doc/BRIEF.md
# GPIO Pad Configuration And Event Detector

This block holds the configuration of one general-purpose I/O pad and turns the pad's input level into an event for an interrupt status collector. Software writes a primary 32-bit configuration word and a secondary word. The primary word selects the pad function, the buffer enables, the driven output value, input inversion, event kind and four interrupt routing enables. The secondary word keeps a resistor termination code and a pull direction. The termination settings are stored but have no effect on the block's outputs.

The pad input passes through a two-flop synchroniser. Its synchronised value appears as a read-only bit in the primary word and feeds the event detector. The detector compares the current detected level with the level from the previous cycle. It can report a level, a one-cycle pulse on a single edge, a pulse on every change, or nothing. A lock input blocks all configuration writes. When the pad is given to a function other than general-purpose I/O, the output driver and the event are both held off.

Top module: `gpio_pad_cell`

## Requirements
- R1: After reset the primary word reads 0x0400_0100, which means the driver is disabled and the event kind is "off". The secondary word reads 0. `pad_oe` and `evt_out` are both 0.
- R2: A write with `wr_en`=1 takes effect at the next clock edge. `wr_sel`=0 selects the primary word and `wr_sel`=1 selects the secondary word. The primary word keeps bits 26:25 (event kind), 23 (invert), 20:17 (routing enables), 13:10 (pad mode), 9 (input disable), 8 (driver disable) and 0 (output value). The secondary word keeps bits 13:10 (bit 13 is the pull direction, bits 12:10 are the termination code). All other bits read 0. `rd_sel` selects the word shown on `rd_data`.
- R3: A write is ignored while `lock_cfg` or `lock_tx` is 1, and both words keep their previous contents.
- R4: Bit 1 of the primary word on `rd_data` shows `pad_in` two clock edges after it is sampled. While bit 9 is set, bit 1 reads 0 and the detector sees a low input.
- R5: `pad_out` equals bit 0. `pad_oe` is 1 only when bit 8 is 0 and the pad mode in bits 13:10 is 0.
- R6: With event kind 0 (level), `evt_out` follows the detected level, which is the received level XOR bit 23. Setting bit 23 therefore makes the event respond to a low input.
- R7: With event kind 1 (single edge), `evt_out` pulses for one cycle when the detected level rises. With bit 23 set, this means a falling edge at the pad.
- R8: With event kind 3 (both edges), `evt_out` pulses for one cycle whenever the detected level changes.
- R9: With event kind 2, `evt_out` stays 0. A nonzero pad mode forces `evt_out` to 0 for every event kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 primary word, 1 secondary word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 primary word, 1 secondary word |
| rd_data | output | 32 | Selected word; bit 1 of the primary word is the live input |
| pad_in | input | 1 | Asynchronous pad input level |
| lock_cfg | input | 1 | Configuration lock |
| lock_tx | input | 1 | Transmit-side lock; also blocks writes |
| pad_out | output | 1 | Value to drive on the pad |
| pad_oe | output | 1 | Output driver enable |
| evt_out | output | 1 | Event toward the interrupt status collector |

## Verification
Directed runs cover each event kind with and without inversion. A slow square wave on `pad_in` separates level behaviour from single-edge and both-edge pulses, and separates rising-edge detection from falling-edge detection. Further directed cases write while each lock input is high, set the input disable, and select a nonzero pad mode, so that blocked writes and forced-off outputs can be told apart from ordinary ones. Constrained random cycles then mix writes, locks, read selects and input toggling, with the pad mode mostly kept at 0 so that event paths stay visible. A cycle model in the bench predicts every output.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int WORD_W = 32;

  // field positions inside the primary word
  localparam int KIND_LO   = 25;
  localparam int INV_BIT   = 23;
  localparam int MODE_LO   = 10;
  localparam int MODE_W    = 4;
  localparam int RXOFF_BIT = 9;
  localparam int TXOFF_BIT = 8;
  localparam int RXLVL_BIT = 1;
  localparam int OUTV_BIT  = 0;

  localparam logic [WORD_W-1:0] PRI_MASK = 32'h069E_3F01;
  localparam logic [WORD_W-1:0] SEC_MASK = 32'h0000_3C00;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_EDGE  = 2'd1,
    EV_OFF   = 2'd2,
    EV_BOTH  = 2'd3
  } evt_kind_e;

  function automatic logic evt_fire(evt_kind_e k, logic det, logic prv);
    case (k)
      EV_LEVEL: return det;
      EV_EDGE:  return det & ~prv;
      EV_BOTH:  return det ^ prv;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic mode_is_gpio(logic [WORD_W-1:0] w);
    return w[MODE_LO +: MODE_W] == '0;
  endfunction
endpackage

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_PRI = 32'h0400_0100,
  parameter logic [WORD_W-1:0] RST_SEC = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              lock_any,
  output logic [WORD_W-1:0] cfg_pri,
  output logic [WORD_W-1:0] cfg_sec
);
  logic wr_ok;
  assign wr_ok = wr_en & ~lock_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_pri <= RST_PRI & PRI_MASK;
      cfg_sec <= RST_SEC & SEC_MASK;
    end else if (wr_ok) begin
      if (wr_sel) cfg_sec <= wr_data & SEC_MASK;
      else        cfg_pri <= wr_data & PRI_MASK;
    end
  end

  a_r3_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_any) |=> ($stable(cfg_pri) && $stable(cfg_sec)));
endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("synchroniser needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_evt.sv
module gpio_pad_evt
  import gpio_pad_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl,
  input  logic      inv,
  input  evt_kind_e kind,
  output logic      evt_raw
);
  logic det, prv;
  assign det = lvl ^ inv;

  always_ff @(posedge clk) begin
    if (!rst_n) prv <= 1'b0;
    else        prv <= det;
  end

  assign evt_raw = evt_fire(kind, det, prv);

  // R7: a single-edge event never lasts two cycles
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_EDGE && evt_raw) |=> !(kind == EV_EDGE && evt_raw));
  // R9: the off kind is silent
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == EV_OFF) |-> !evt_raw);
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_pad_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] RST_PRI     = 32'h0400_0100,
  parameter logic [WORD_W-1:0] RST_SEC     = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              pad_in,
  input  logic              lock_cfg,
  input  logic              lock_tx,
  output logic              pad_out,
  output logic              pad_oe,
  output logic              evt_out
);
  logic [WORD_W-1:0] cfg_pri, cfg_sec;
  logic              lock_any, in_sync, rx_lvl, evt_raw, gpio_mode;

  assign lock_any = lock_cfg | lock_tx;

  gpio_pad_regs #(.RST_PRI(RST_PRI), .RST_SEC(RST_SEC)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .lock_any(lock_any),
    .cfg_pri(cfg_pri), .cfg_sec(cfg_sec)
  );

  gpio_pad_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync)
  );

  assign rx_lvl = in_sync & ~cfg_pri[RXOFF_BIT];

  gpio_pad_evt evt_i (
    .clk(clk), .rst_n(rst_n), .lvl(rx_lvl), .inv(cfg_pri[INV_BIT]),
    .kind(evt_kind_e'(cfg_pri[KIND_LO +: 2])), .evt_raw(evt_raw)
  );

  assign gpio_mode = mode_is_gpio(cfg_pri);
  assign pad_out   = cfg_pri[OUTV_BIT];
  assign pad_oe    = gpio_mode & ~cfg_pri[TXOFF_BIT];
  assign evt_out   = gpio_mode & evt_raw;

  always_comb begin
    if (rd_sel) rd_data = cfg_sec;
    else begin
      rd_data            = cfg_pri;
      rd_data[RXLVL_BIT] = rx_lvl;
    end
  end

  // R5 / R9: an accepted write of a nonzero mode silences driver and event
  a_r5_mode_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_cfg && !lock_tx && !wr_sel && wr_data[MODE_LO +: MODE_W] != '0)
      |=> (!pad_oe && !evt_out));
  // R4: input disable hides the live level
  a_r4_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_sel && cfg_pri[RXOFF_BIT]) |-> !rd_data[RXLVL_BIT]);
endmodule

// File: tb/gpio_pad_cell_tb.sv
module gpio_pad_cell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] M_PRI = 32'h069E_3F01;
  localparam logic [31:0] M_SEC = 32'h0000_3C00;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, pad_in = 0, lock_cfg = 0, lock_tx = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic pad_out, pad_oe, evt_out;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_pri, m_sec;
  logic m_s1, m_s2, m_prv;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pad_cell dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .pad_in(pad_in), .lock_cfg(lock_cfg),
    .lock_tx(lock_tx), .pad_out(pad_out), .pad_oe(pad_oe), .evt_out(evt_out)
  );

  function automatic logic f_rx(logic [31:0] p, logic s2);
    return s2 && !p[9];
  endfunction
  function automatic logic f_det(logic [31:0] p, logic s2);
    return f_rx(p, s2) != p[23];
  endfunction
  function automatic logic f_evt(logic [31:0] p, logic s2, logic prv);
    logic d;
    d = f_det(p, s2);
    if (p[13:10] != 0) return 1'b0;
    case (p[26:25])
      2'd0: return d;
      2'd1: return d && !prv;
      2'd3: return d != prv;
      default: return 1'b0;
    endcase
  endfunction
  function automatic string f_tag(logic [31:0] p);
    if (p[13:10] != 0) return "R9";
    case (p[26:25])
      2'd0: return "R6";
      2'd1: return "R7";
      2'd3: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [31:0] e_rd;
    e_rd = rd_sel ? m_sec : (m_pri | {30'd0, f_rx(m_pri, m_s2), 1'b0});
    chk(rd_sel ? "R2" : "R4", rd_data, e_rd);
    chk("R5", {31'd0, pad_out}, {31'd0, m_pri[0]});
    chk("R5", {31'd0, pad_oe}, {31'd0, (m_pri[13:10] == 0) && !m_pri[8]});
    chk(f_tag(m_pri), {31'd0, evt_out}, {31'd0, f_evt(m_pri, m_s2, m_prv)});
  endtask

  task automatic step();
    logic np;
    @(posedge clk);
    if (!rst_n) begin
      m_pri = 32'h0400_0100; m_sec = 0; m_s1 = 0; m_s2 = 0; m_prv = 0;
    end else begin
      np = f_det(m_pri, m_s2);
      m_s2 = m_s1; m_s1 = pad_in; m_prv = np;
      if (wr_en && !lock_cfg && !lock_tx) begin
        if (wr_sel) m_sec = wr_data & M_SEC;
        else        m_pri = wr_data & M_PRI;
      end
    end
    @(negedge clk);
    if (rst_n) check_all();
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic square(int half, int periods);
    for (int p = 0; p < periods; p++) begin
      pad_in = 1; repeat (half) step();
      pad_in = 0; repeat (half) step();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1", rd_data, 32'h0400_0100);
    chk("R1", {30'd0, pad_oe, evt_out}, 32'd0);
    rd_sel = 1; step(); chk("R1", rd_data, 32'd0); rd_sel = 0;

    // R2 masked storage of both words
    wr(0, 32'hFFFF_FFFF); chk("R2", rd_data & ~32'h2, M_PRI);
    wr(1, 32'hFFFF_FFFF); rd_sel = 1; step(); chk("R2", rd_data, M_SEC); rd_sel = 0;

    // R3 locks block writes
    wr(0, 32'h0000_0001);
    lock_cfg = 1; wr(0, 32'h0000_0000); chk("R3", {31'd0, pad_out}, 32'd1);
    lock_cfg = 0; lock_tx = 1; wr(1, 32'h0); rd_sel = 1; step();
    chk("R3", rd_data, M_SEC); rd_sel = 0; lock_tx = 0;

    // R5 driver enabled in gpio mode
    wr(0, 32'h0400_0001); chk("R5", {31'd0, pad_oe}, 32'd1);

    // R4 two-cycle latency of the live bit
    pad_in = 1; step(); chk("R4", {31'd0, rd_data[1]}, 32'd0);
    step(); chk("R4", {31'd0, rd_data[1]}, 32'd1);
    wr(0, 32'h0400_0200); chk("R4", {31'd0, rd_data[1]}, 32'd0);
    pad_in = 0; repeat (3) step();

    // R6 level, plain and inverted
    wr(0, 32'h0000_0000); square(4, 2);
    wr(0, 32'h0080_0000); square(4, 2);
    // R7 single edge, rising then falling
    wr(0, 32'h0200_0000); repeat (3) step(); square(5, 2);
    wr(0, 32'h0280_0000); repeat (3) step(); square(5, 2);
    // R8 both edges
    wr(0, 32'h0600_0000); repeat (3) step(); square(3, 3);
    // R9 off kind, and nonzero mode with level kind
    wr(0, 32'h0400_0000); square(3, 2);
    wr(0, 32'h0000_0C00); square(3, 2);
    chk("R9", {31'd0, evt_out}, 32'd0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(3) != 0) d[13:10] = 0;
      wr_en    = ($urandom_range(7) == 0);
      wr_sel   = ($urandom_range(3) == 0);
      wr_data  = d;
      lock_cfg = ($urandom_range(7) == 0);
      lock_tx  = ($urandom_range(7) == 0);
      rd_sel   = $urandom_range(1);
      if ($urandom_range(2) == 0) pad_in = ~pad_in;
      step();
    end
    wr_en = 0; lock_cfg = 0; lock_tx = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule